// File: doc/BRIEF.md
# I2C Master Register Front End

This block is the software-facing half of an I2C master. It holds a command FIFO that software fills and a serial engine drains. It also holds a receive FIFO that the engine fills and software drains. Both FIFOs have programmable watermarks. A transmit-request flag and a receive-ready flag follow those watermarks. Events reported by the engine (stop seen, missing acknowledge, lost arbitration) and a transmit overflow are latched in sticky flags, which software clears by writing ones. A single interrupt line combines the enabled flags.

Software reaches the block through a word-addressed register port with eight registers. Reads are combinational, and writes and pops take effect at the clock edge. The engine connects through a pop handshake on the command FIFO, a push strobe on the receive FIFO, single-cycle event strobes and two busy levels. A control bit gates whether commands are offered to the engine. Another control bit holds both FIFOs and all sticky flags in a cleared state for as long as it is set.

Register map (word index on `reg_addr`): 0 info, 1 control, 2 status, 3 interrupt enable, 4 watermarks, 5 fill counts, 6 command write, 7 receive read.

Top module: `twh_front`

## Requirements
- R1: A read of the info word (index 0) returns log2 of the command FIFO depth in bits [3:0] and log2 of the receive FIFO depth in bits [11:8]; all other bits are zero.
- R2: A write to index 6 appends `reg_wdata[CMD_W-1:0]` to the command FIFO. The engine receives the entries in write order on `cmd_data`. `cmd_valid` is high only when control bit 0 is set and the FIFO is not empty, and each `cmd_pop` while `cmd_valid` is high removes one entry.
- R3: A command write to a full FIFO is discarded and sets sticky status bit 12. Bit 12 can never reach `irq`: the interrupt-enable register stores 0 in bit 12 whatever is written there.
- R4: A read of index 7 returns the oldest received byte in bits [7:0] and removes it from the receive FIFO. When the FIFO is empty, the read returns 0x4000 (bit 14 set, byte zero) and removes nothing.
- R5: The watermark word (index 4) holds the command watermark in its low bits and the receive watermark from bit 16 upward, and reads back as written. Status bit 0 is set while the command fill count is at or below its watermark. Status bit 1 is set while the receive fill count is above its watermark.
- R6: Status bits 9, 10 and 11 latch the `ev_stop`, `ev_nack` and `ev_arb` strobes. Writing 1 to a bit in [14:8] of the status word clears that bit, and writing 0 leaves it unchanged. An event that arrives in the same cycle as its clear leaves the bit set. Writing 0x7F00 clears every sticky bit.
- R7: `irq` is high when any status bit among 0, 1, 9, 10 and 11 is set together with the same bit of the interrupt-enable register (index 3). With the default parameters, `irq` follows in the same cycle.
- R8: Writing control bit 8 empties the command FIFO, and writing control bit 9 empties the receive FIFO, both at that clock edge. Bits 8 and 9 always read back as 0.
- R9: While control bit 1 is set, both FIFOs are held empty and all sticky bits are held clear, from the cycle after it is written until it is written back to 0.
- R10: The fill-count word (index 5) gives the command count in bits [7:0] and the receive count from bit 16 upward. Status bits 24 and 25 mirror `eng_busy` and `bus_busy`.
- R11: After reset, every FIFO is empty and every register is zero, `irq` and `cmd_valid` are low, and status reads 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at index 7) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Combined interrupt |
| core_en | output | 1 | Control bit 0, engine enable |
| cmd_valid | output | 1 | A command is offered to the engine |
| cmd_pop | input | 1 | Engine takes the offered command |
| cmd_data | output | CMD_W | Oldest command word |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| ev_stop | input | 1 | Stop condition seen (strobe) |
| ev_nack | input | 1 | Acknowledge missing (strobe) |
| ev_arb | input | 1 | Arbitration lost (strobe) |
| eng_busy | input | 1 | Engine busy level |
| bus_busy | input | 1 | Bus busy level |

## Verification
The hardest case to reach from the ports is a sticky event whose strobe lands in the same cycle as a write-1 clear of the same bit. To reach it, the bench drives the status write and the `ev_arb` strobe on the same falling edge, so both meet the same rising edge, and then reads the flag back. A second hard case is a write to the full command FIFO. Because commands are only offered to the engine while control bit 0 is set, the bench fills the FIFO with bit 0 clear, so nothing drains it before the extra write. A third is the one-cycle gap between setting the hold-in-reset control bit and the counts reaching zero. The bench waits one idle cycle before it reads the counts.

// File: rtl/twh_pkg.sv
package twh_pkg;
   typedef enum logic [2:0] {
      A_INFO = 3'd0,
      A_CTRL = 3'd1,
      A_STAT = 3'd2,
      A_IEN  = 3'd3,
      A_WMRK = 3'd4,
      A_FILL = 3'd5,
      A_CMD  = 3'd6,
      A_RXD  = 3'd7
   } reg_addr_e;

   localparam int ST_TXREQ  = 0;
   localparam int ST_RXRDY  = 1;
   localparam int EV_LO     = 8;
   localparam int EV_N      = 7;
   localparam int EV_STOP   = 1;   // offsets inside the sticky field
   localparam int EV_NACK   = 2;
   localparam int EV_ARB    = 3;
   localparam int EV_OVF    = 4;
   localparam int ST_MBUSY  = 24;
   localparam int ST_BBUSY  = 25;
   localparam int RX_NONE   = 14;
   localparam int CT_EN     = 0;
   localparam int CT_SRST   = 1;
   localparam int CT_TXFL   = 8;
   localparam int CT_RXFL   = 9;
   localparam logic [31:0] IEN_MASK = 32'h0000_0E03;
endpackage

// File: rtl/twh_fifo.sv
module twh_fifo #(
   parameter int LOG2 = 2,
   parameter int W    = 8,
   localparam int DEPTH = 1 << LOG2,
   localparam int CW    = LOG2 + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   logic [W-1:0]      mem [DEPTH];
   logic [LOG2-1:0]   wp, rp;
   logic              do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign rdata   = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (count == $past(count)));
   assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> empty);
   assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));
endmodule

// File: rtl/twh_sticky.sv
module twh_sticky #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] set,
   input  logic         w1c_en,
   input  logic [N-1:0] w1c,
   output logic [N-1:0] q
);
   logic [N-1:0] keep;
   assign keep = w1c_en ? ~w1c : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else          q <= (q & keep) | set;
   end

   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && (set != '0)) |=> ((q & $past(set)) == $past(set)));
   assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && w1c_en && ((w1c & ~set) != '0)) |=> ((q & $past(w1c & ~set)) == '0));
   assert_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0));
endmodule

// File: rtl/twh_front.sv
module twh_front
   import twh_pkg::*;
#(
   parameter int TX_LOG2 = 2,
   parameter int RX_LOG2 = 2,
   parameter int CMD_W   = 11,
   parameter bit IRQ_REG = 1'b0,
   localparam int TX_CW  = TX_LOG2 + 1,
   localparam int RX_CW  = RX_LOG2 + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [2:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   output logic             irq,
   output logic             core_en,
   output logic             cmd_valid,
   input  logic             cmd_pop,
   output logic [CMD_W-1:0] cmd_data,
   input  logic             rx_push,
   input  logic [7:0]       rx_byte,
   input  logic             ev_stop,
   input  logic             ev_nack,
   input  logic             ev_arb,
   input  logic             eng_busy,
   input  logic             bus_busy
);
   if (TX_LOG2 < 1 || TX_LOG2 > 7) begin : g_bad_tx
      $error("TX_LOG2 must lie in 1..7");
   end
   if (RX_LOG2 < 1 || RX_LOG2 > 7) begin : g_bad_rx
      $error("RX_LOG2 must lie in 1..7");
   end
   if (CMD_W < 8 || CMD_W > 32) begin : g_bad_cw
      $error("CMD_W must lie in 8..32");
   end

   logic              en_q, srst_q;
   logic [31:0]       ien_q;
   logic [TX_CW-1:0]  tx_wm_q, tx_cnt;
   logic [RX_CW-1:0]  rx_wm_q, rx_cnt;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic [7:0]        rx_head;
   logic [EV_N-1:0]   ev_q, ev_set;
   logic              wr_ctrl, tx_flush, rx_flush, tx_push, rx_pop;
   logic [31:0]       stat, rd_mux;
   logic              irq_raw;
   logic              unused_bits;

   assign unused_bits = ^{reg_wdata, rx_full};

   assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
   assign tx_flush = srst_q || (wr_ctrl && reg_wdata[CT_TXFL]);
   assign rx_flush = srst_q || (wr_ctrl && reg_wdata[CT_RXFL]);
   assign tx_push  = reg_wr && (reg_addr == A_CMD);
   assign rx_pop   = reg_rd && (reg_addr == A_RXD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         srst_q  <= 1'b0;
         ien_q   <= '0;
         tx_wm_q <= '0;
         rx_wm_q <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            A_CTRL: begin
               en_q   <= reg_wdata[CT_EN];
               srst_q <= reg_wdata[CT_SRST];
            end
            A_IEN:  ien_q <= reg_wdata & IEN_MASK;
            A_WMRK: begin
               tx_wm_q <= reg_wdata[TX_CW-1:0];
               rx_wm_q <= reg_wdata[16 +: RX_CW];
            end
            default: ;
         endcase
      end
   end

   twh_fifo #(.LOG2(TX_LOG2), .W(CMD_W)) u_cmdq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push(tx_push), .wdata(reg_wdata[CMD_W-1:0]),
      .pop(cmd_pop && cmd_valid), .rdata(cmd_data),
      .count(tx_cnt), .full(tx_full), .empty(tx_empty));

   twh_fifo #(.LOG2(RX_LOG2), .W(8)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push(rx_push), .wdata(rx_byte),
      .pop(rx_pop), .rdata(rx_head),
      .count(rx_cnt), .full(rx_full), .empty(rx_empty));

   always_comb begin
      ev_set          = '0;
      ev_set[EV_STOP] = ev_stop;
      ev_set[EV_NACK] = ev_nack;
      ev_set[EV_ARB]  = ev_arb;
      ev_set[EV_OVF]  = tx_push && tx_full && !tx_flush;
   end

   twh_sticky #(.N(EV_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .clr(srst_q), .set(ev_set),
      .w1c_en(reg_wr && (reg_addr == A_STAT)),
      .w1c(reg_wdata[EV_LO +: EV_N]), .q(ev_q));

   always_comb begin
      stat                  = '0;
      stat[ST_TXREQ]        = (tx_cnt <= tx_wm_q);
      stat[ST_RXRDY]        = (rx_cnt > rx_wm_q);
      stat[EV_LO +: EV_N]   = ev_q;
      stat[ST_MBUSY]        = eng_busy;
      stat[ST_BBUSY]        = bus_busy;
   end

   assign irq_raw   = |(stat & ien_q);
   assign core_en   = en_q;
   assign cmd_valid = en_q && !tx_empty;

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end

   always_comb begin
      rd_mux = '0;
      case (reg_addr)
         A_INFO: begin
            rd_mux[3:0]  = 4'(TX_LOG2);
            rd_mux[11:8] = 4'(RX_LOG2);
         end
         A_CTRL: begin
            rd_mux[CT_EN]   = en_q;
            rd_mux[CT_SRST] = srst_q;
         end
         A_STAT: rd_mux = stat;
         A_IEN:  rd_mux = ien_q;
         A_WMRK: begin
            rd_mux[TX_CW-1:0]  = tx_wm_q;
            rd_mux[16 +: RX_CW] = rx_wm_q;
         end
         A_FILL: begin
            rd_mux[TX_CW-1:0]  = tx_cnt;
            rd_mux[16 +: RX_CW] = rx_cnt;
         end
         A_RXD: begin
            rd_mux[7:0]     = rx_empty ? 8'h00 : rx_head;
            rd_mux[RX_NONE] = rx_empty;
         end
         default: rd_mux = '0;
      endcase
   end
   assign reg_rdata = rd_mux;

   assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> (tx_cnt == '0 && rx_cnt == '0 && ev_q == '0));
   assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0 && $past(ien_q) == '0) |-> !irq);
   assert_ovf_unrouted_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ien_q[EV_LO + EV_OVF]);
endmodule

// File: tb/tb_twh_front.sv
`timescale 1ns/1ps
module tb_twh_front;
   localparam int CMD_W = 11;

   typedef struct packed {
      logic        rd;
      logic [2:0]  a;
      logic [31:0] d;
      logic [31:0] e;
      logic        irq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 23;
   // R1 info, R11 reset, R5 watermarks, R2 push, R10 counts, R3 overflow,
   // R7 enable masking, R6 clear, R8 flush
   localparam vec_t VT [NV] = '{
      '{1'b1, 3'd0, 32'h0,          32'h0000_0202, 1'b0, 4'd1},
      '{1'b1, 3'd2, 32'h0,          32'h0000_0001, 1'b0, 4'd11},
      '{1'b1, 3'd5, 32'h0,          32'h0000_0000, 1'b0, 4'd11},
      '{1'b0, 3'd4, 32'h0001_0001,  32'h0,         1'b0, 4'd5},
      '{1'b1, 3'd4, 32'h0,          32'h0001_0001, 1'b0, 4'd5},
      '{1'b0, 3'd6, 32'h0000_04A5,  32'h0,         1'b0, 4'd2},
      '{1'b1, 3'd5, 32'h0,          32'h0000_0001, 1'b0, 4'd10},
      '{1'b1, 3'd2, 32'h0,          32'h0000_0001, 1'b0, 4'd5},
      '{1'b0, 3'd6, 32'h0000_0012,  32'h0,         1'b0, 4'd2},
      '{1'b1, 3'd2, 32'h0,          32'h0000_0000, 1'b0, 4'd5},
      '{1'b0, 3'd6, 32'h0000_0034,  32'h0,         1'b0, 4'd2},
      '{1'b0, 3'd6, 32'h0000_0056,  32'h0,         1'b0, 4'd2},
      '{1'b0, 3'd6, 32'h0000_0078,  32'h0,         1'b0, 4'd3},
      '{1'b1, 3'd5, 32'h0,          32'h0000_0004, 1'b0, 4'd3},
      '{1'b1, 3'd2, 32'h0,          32'h0000_1000, 1'b0, 4'd3},
      '{1'b0, 3'd3, 32'h0000_1E03,  32'h0,         1'b0, 4'd7},
      '{1'b1, 3'd3, 32'h0,          32'h0000_0E03, 1'b0, 4'd3},
      '{1'b0, 3'd2, 32'h0000_1000,  32'h0,         1'b0, 4'd6},
      '{1'b1, 3'd2, 32'h0,          32'h0000_0000, 1'b0, 4'd6},
      '{1'b0, 3'd1, 32'h0000_0100,  32'h0,         1'b1, 4'd8},
      '{1'b1, 3'd5, 32'h0,          32'h0000_0000, 1'b1, 4'd8},
      '{1'b1, 3'd1, 32'h0,          32'h0000_0000, 1'b1, 4'd8},
      '{1'b0, 3'd3, 32'h0,          32'h0,         1'b0, 4'd7}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]       reg_addr = '0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic             irq, core_en, cmd_valid;
   logic             cmd_pop = 1'b0;
   logic [CMD_W-1:0] cmd_data;
   logic             rx_push = 1'b0;
   logic [7:0]       rx_byte = '0;
   logic             ev_stop = 1'b0, ev_nack = 1'b0, ev_arb = 1'b0;
   logic             eng_busy = 1'b0, bus_busy = 1'b0;

   int nchk = 0;
   int nfail = 0;
   logic [31:0] rv;

   always #2 clk = ~clk;

   twh_front #(.CMD_W(CMD_W)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .core_en(core_en), .cmd_valid(cmd_valid), .cmd_pop(cmd_pop),
      .cmd_data(cmd_data), .rx_push(rx_push), .rx_byte(rx_byte),
      .ev_stop(ev_stop), .ev_nack(ev_nack), .ev_arb(ev_arb),
      .eng_busy(eng_busy), .bus_busy(bus_busy));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic rx_in(input logic [7:0] b);
      @(negedge clk);
      rx_push = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic pop_cmd();
      @(negedge clk);
      cmd_pop = 1'b1;
      @(negedge clk);
      cmd_pop = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset outputs
      check("R11 irq", {31'b0, irq}, 32'h0);
      check("R11 cmd_valid", {31'b0, cmd_valid}, 32'h0);
      check("R11 core_en", {31'b0, core_en}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VT[i].rd) begin
            rd(VT[i].a, rv);
            check($sformatf("R%0d vec%0d data", VT[i].req, i), rv, VT[i].e);
         end else begin
            wr(VT[i].a, VT[i].d);
         end
         check($sformatf("R%0d vec%0d irq", VT[i].req, i), {31'b0, irq}, {31'b0, VT[i].irq});
      end

      // R2 engine side order and enable gating
      wr(3'd1, 32'h1);
      check("R2 core_en", {31'b0, core_en}, 32'h1);
      wr(3'd6, 32'h4A5);
      wr(3'd6, 32'h012);
      wr(3'd6, 32'h3FF);
      check("R2 valid", {31'b0, cmd_valid}, 32'h1);
      check("R2 head0", 32'(cmd_data), 32'h4A5);
      pop_cmd();
      check("R2 head1", 32'(cmd_data), 32'h012);
      pop_cmd();
      check("R2 head2", 32'(cmd_data), 32'h3FF);
      pop_cmd();
      check("R2 drained", {31'b0, cmd_valid}, 32'h0);
      wr(3'd6, 32'h0AA);
      wr(3'd1, 32'h0);
      check("R2 gated", {31'b0, cmd_valid}, 32'h0);
      pop_cmd();
      rd(3'd5, rv);
      check("R2 pop ignored while gated", rv, 32'h1);
      wr(3'd1, 32'h100);

      // R4 receive path
      rd(3'd7, rv);
      check("R4 empty read", rv, 32'h4000);
      rx_in(8'h11);
      rx_in(8'h22);
      rd(3'd5, rv);
      check("R10 rx count", rv, 32'h0002_0000);
      rd(3'd2, rv);
      check("R5 rx ready", rv, 32'h3);
      rd(3'd7, rv);
      check("R4 byte0", rv, 32'h11);
      rd(3'd7, rv);
      check("R4 byte1", rv, 32'h22);
      rd(3'd7, rv);
      check("R4 empty again", rv, 32'h4000);
      rd(3'd5, rv);
      check("R4 no underflow", rv, 32'h0);
      rx_in(8'h33);
      wr(3'd1, 32'h200);
      rd(3'd5, rv);
      check("R8 rx flush", rv, 32'h0);

      // R6 sticky events and R7 interrupt
      @(negedge clk);
      ev_stop = 1'b1; ev_nack = 1'b1;
      @(negedge clk);
      ev_stop = 1'b0; ev_nack = 1'b0;
      rd(3'd2, rv);
      check("R6 latched", rv, 32'h601);
      wr(3'd3, 32'h400);
      check("R7 nack irq", {31'b0, irq}, 32'h1);
      wr(3'd2, 32'h200);
      rd(3'd2, rv);
      check("R6 w1c", rv, 32'h401);
      wr(3'd2, 32'h0);
      rd(3'd2, rv);
      check("R6 write zero", rv, 32'h401);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h800; ev_arb = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; ev_arb = 1'b0;
      rd(3'd2, rv);
      check("R6 set wins", rv, 32'hC01);
      wr(3'd2, 32'h7F00);
      rd(3'd2, rv);
      check("R6 clear all", rv, 32'h1);
      check("R7 irq drops", {31'b0, irq}, 32'h0);
      wr(3'd3, 32'h0);

      // R9 hold in reset
      wr(3'd6, 32'h001);
      rx_in(8'h44);
      @(negedge clk);
      ev_stop = 1'b1;
      @(negedge clk);
      ev_stop = 1'b0;
      wr(3'd1, 32'h2);
      @(negedge clk);
      rd(3'd5, rv);
      check("R9 fifos empty", rv, 32'h0);
      rd(3'd2, rv);
      check("R9 flags clear", rv, 32'h1);
      wr(3'd6, 32'h055);
      rd(3'd5, rv);
      check("R9 held empty", rv, 32'h0);
      wr(3'd1, 32'h0);

      // R10 busy mirrors
      @(negedge clk);
      eng_busy = 1'b1; bus_busy = 1'b1;
      rd(3'd2, rv);
      check("R10 busy", rv, 32'h0300_0001);
      eng_busy = 1'b0; bus_busy = 1'b0;

      finish_run();
   end
endmodule